// File: doc/BRIEF.md
# Two-Wire Pointer-Register Target

This block is the bus-facing half of a small sensor-style peripheral. It listens on a two-wire serial bus as a target, that is, as the side that does not drive the clock. It oversamples SCL and SDA on the system clock and spots START and STOP conditions. It answers one 7-bit address. The upper bits of that address are a build-time constant. The low bits are captured from address-strap inputs.

Behind the bus logic sits a pointer register. The pointer picks one word of an external register file, and each word is a whole number of bytes (16 bits by default). In a write transaction the first byte after the address always lands in the pointer. Any following bytes are packed into words and sent to the register file. A read transaction returns the word that the pointer selects, high byte first. The pointer keeps its value between transactions, so a master can read the same register again and again without rewriting it.

Writes to the register file go through a single-cycle strobe, `rf_wr`, with no ready. The bus cannot be held off, because clock stretching is not supported, so the register file must accept the word in the cycle the strobe is high. Reads use a combinational lookup on `rf_ptr`.

The general-call address is also decoded. Command 0x04 re-captures the address straps. Command 0x06 re-captures them, clears the pointer and pulses a defaults request to the register file.

Top module: `i2c_ptr_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP the block ignores all bus traffic until the next START, and it acknowledges nothing in that time.
- R2: The block compares the first byte after a START as 7 address bits, most significant first, followed by the R/W bit (1 = read). On a match it pulls SDA low for the ninth clock. On a mismatch it never drives SDA during that transaction.
- R3: In a write transaction the first byte after the address goes into the pointer and is acknowledged.
- R4: Data bytes after the pointer byte are each acknowledged. They are packed high byte first, and each completed word is written to the register the pointer selects with one single-cycle `rf_wr` strobe. Further bytes form further words for the same register.
- R5: A read returns the selected register's high byte, then its low byte. Reads never change the pointer, and the pointer persists across transactions.
- R6: A master Not-Acknowledge after a read byte ends the transfer. The block then leaves SDA released until the next START.
- R7: The general-call address 0000000 with R/W = 0 is acknowledged. Every following byte is taken as a command and acknowledged, and command 0x04 re-captures the address straps without touching registers or pointer.
- R8: General-call command 0x06 re-captures the address straps, sets the pointer to 0 and pulses `rf_defaults` for one cycle, which returns the register file to its defaults.
- R9: A pointer value of NREGS or more selects no register. Reads then return 0x00 bytes, written data is dropped (`rf_wr` stays low), and every byte is still acknowledged.
- R10: A START arriving partway through a byte drops that byte and restarts address matching.
- R11: SDA is driven only low, through `sda_oe`. The enable only turns on while SCL is low. The acknowledge is released on the SCL falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low reset; also captures the address straps |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_pins | input | NPINS | Address straps forming the low address bits |
| rf_ptr | output | PTR_W | Current pointer, selects the register file word |
| rf_rdata | input | 8*REG_BYTES | Register file word at `rf_ptr` |
| rf_wr | output | 1 | Single-cycle write strobe to the register file |
| rf_wdata | output | 8*REG_BYTES | Word written when `rf_wr` is high |
| rf_defaults | output | 1 | Single-cycle request to restore register defaults |

## Verification
The bench targets pointer persistence. A design that reset the pointer at STOP would return register 0 on a later read that skips the pointer byte. It probes a pointer past the last register: a design that passed raw register data or suppressed the acknowledge would show wrong bytes or a high ACK bit. It also breaks off a byte with a repeated START, after which a design that kept the stale bit count would mis-frame the address and stay silent. For the general-call commands, the bench moves the straps and checks that the old address goes silent only after 0x04 or 0x06. After 0x06 it checks that the default comes back without a pointer write.

// File: rtl/i2c_ps_pkg.sv
package i2c_ps_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_DEC, S_ACK, S_TX, S_MACK, S_MACKF
  } st_t;

  typedef enum logic [1:0] {PH_ADDR, PH_PTR, PH_DATA, PH_GC} ph_t;

  localparam logic [7:0] GC_RELATCH = 8'h04;
  localparam logic [7:0] GC_RESET   = 8'h06;
endpackage

// File: rtl/i2c_ps_sync.sv
module i2c_ps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_ps_cond.sv
module i2c_ps_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start,
  output logic stop
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw, syn, prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_ps_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[g]), .q(syn[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= syn;
  end

  assign scl_s    = syn[1];
  assign sda_s    = syn[0];
  assign scl_rise = syn[1] & ~prev[1];
  assign scl_fall = ~syn[1] & prev[1];
  assign start    = syn[1] & prev[1] & prev[0] & ~syn[0];
  assign stop     = syn[1] & prev[1] & ~prev[0] & syn[0];
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
  import i2c_ps_pkg::*;
#(
  parameter int         NPINS       = 2,
  parameter logic [6:0] BASE_ADDR   = 7'h48,
  parameter int         NREGS       = 4,
  parameter int         REG_BYTES   = 2,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic [NPINS-1:0]       addr_pins,
  output logic [PTR_W-1:0]       rf_ptr,
  input  logic [8*REG_BYTES-1:0] rf_rdata,
  output logic                   rf_wr,
  output logic [8*REG_BYTES-1:0] rf_wdata,
  output logic                   rf_defaults
);
  localparam int REG_W = 8 * REG_BYTES;
  localparam int BI_W  = (REG_BYTES > 2) ? $clog2(REG_BYTES) : 1;
  localparam logic [BI_W-1:0] LAST_BI = BI_W'(REG_BYTES - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  i2c_ps_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start(start), .stop(stop)
  );

  st_t               st;
  ph_t               ph;
  logic [2:0]        cnt;
  logic [7:0]        sh, tsh, tx_sel;
  logic              rw;
  logic [PTR_W-1:0]  ptr;
  logic [NPINS-1:0]  pins_q;
  logic [BI_W-1:0]   bi;
  logic [REG_W-1:0]  wacc, snap;
  logic [6:0]        my_addr;
  logic              ptr_ok;

  assign my_addr = {BASE_ADDR[6:NPINS], pins_q};
  assign ptr_ok  = (ptr < PTR_W'(NREGS));
  assign tx_sel  = snap[REG_W-1-8*int'(bi) -: 8];
  assign rf_ptr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_ADDR; cnt <= '0; sh <= '0; tsh <= '0;
      rw <= 1'b0; ptr <= '0; pins_q <= addr_pins; bi <= '0;
      wacc <= '0; snap <= '0; sda_oe <= 1'b0;
      rf_wr <= 1'b0; rf_wdata <= '0; rf_defaults <= 1'b0;
    end else begin
      rf_wr       <= 1'b0;
      rf_defaults <= 1'b0;
      if (start) begin
        st <= S_RX; ph <= PH_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            sh <= {sh[6:0], sda_s};
            if (cnt == 3'd7) st <= S_DEC;
            else             cnt <= cnt + 3'd1;
          end
          S_DEC: if (scl_fall) begin
            cnt <= '0;
            st  <= S_IDLE;
            case (ph)
              PH_ADDR: begin
                if (sh[7:1] == my_addr) begin
                  sda_oe <= 1'b1; st <= S_ACK; rw <= sh[0];
                  ph <= PH_PTR; bi <= '0;
                  snap <= ptr_ok ? rf_rdata : '0;
                end else if (sh == 8'h00) begin
                  sda_oe <= 1'b1; st <= S_ACK; rw <= 1'b0; ph <= PH_GC;
                end
              end
              PH_PTR: begin
                ptr <= sh; sda_oe <= 1'b1; st <= S_ACK;
                ph <= PH_DATA; bi <= '0;
              end
              PH_DATA: begin
                sda_oe <= 1'b1; st <= S_ACK;
                wacc <= {wacc[REG_W-9:0], sh};
                if (bi == LAST_BI) begin
                  bi <= '0;
                  rf_wr <= ptr_ok;
                  rf_wdata <= {wacc[REG_W-9:0], sh};
                end else begin
                  bi <= bi + 1'b1;
                end
              end
              default: begin
                sda_oe <= 1'b1; st <= S_ACK;
                if (sh == GC_RELATCH || sh == GC_RESET) pins_q <= addr_pins;
                if (sh == GC_RESET) begin
                  ptr <= '0; rf_defaults <= 1'b1;
                end
              end
            endcase
          end
          S_ACK: if (scl_fall) begin
            if (rw) begin
              st <= S_TX; tsh <= tx_sel; sda_oe <= ~tx_sel[7];
              bi <= (bi == LAST_BI) ? '0 : bi + 1'b1;
            end else begin
              st <= S_RX; sda_oe <= 1'b0;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0; st <= S_MACK; cnt <= '0;
            end else begin
              cnt <= cnt + 3'd1; tsh <= {tsh[6:0], 1'b0}; sda_oe <= ~tsh[6];
            end
          end
          S_MACK: if (scl_rise) st <= sda_s ? S_IDLE : S_MACKF;
          S_MACKF: if (scl_fall) begin
            st <= S_TX; tsh <= tx_sel; sda_oe <= ~tx_sel[7];
            bi <= (bi == LAST_BI) ? '0 : bi + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R11
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe); // R1
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> !rf_wr); // R4
  AST_WR_VALID_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> (rf_ptr < PTR_W'(NREGS))); // R9
  AST_READ_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX) |=> $stable(rf_ptr)); // R5
  AST_DEFAULTS_PTR0: assert property (@(posedge clk) disable iff (!rst_n)
    rf_defaults |-> (rf_ptr == '0)); // R8
endmodule

// File: tb/test_i2c_ptr_slave.sv
module test_i2c_ptr_slave;
  localparam int         NREGS = 4;
  localparam logic [6:0] BASE  = 7'h48;
  localparam int         Q     = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1, sda_line, sda_oe;
  logic [1:0]  pins = 2'b01;
  logic [7:0]  rf_ptr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_wr, rf_def;
  logic [15:0] mem [NREGS];
  logic [15:0] exp_mem [NREGS];
  int   exp_ptr = 0;
  logic [1:0] cur_pins = 2'b01;
  int   checks = 0, fails = 0;
  bit   done = 0;

  assign sda_line = sda_m & ~sda_oe;
  assign rf_rdata = mem[rf_ptr[1:0]];

  function automatic logic [15:0] dflt(int i);
    return 16'hA050 + 16'(i) * 16'h0111;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || rf_def) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= dflt(i);
    end else if (rf_wr) begin
      mem[rf_ptr[1:0]] <= rf_wdata;
    end
  end

  i2c_ptr_slave i_i2c_ptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(pins), .rf_ptr(rf_ptr), .rf_rdata(rf_rdata), .rf_wr(rf_wr),
    .rf_wdata(rf_wdata), .rf_defaults(rf_def)
  );

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(Q); scl = 1'b1; wt(2 * Q); scl = 1'b0; wt(Q);
    end
  endtask

  task automatic send(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); ack = sda_line; wt(Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic recv(logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl = 1'b0;
    end
    wt(1); sda_m = nack; wt(Q - 1); scl = 1'b1; wt(2 * Q); scl = 1'b0; wt(Q);
  endtask

  function automatic logic [7:0] adr(logic rw);
    return {BASE[6:2], cur_pins, rw};
  endfunction

  function automatic logic [15:0] expect_rd();
    return (exp_ptr < NREGS) ? exp_mem[exp_ptr] : 16'h0000;
  endfunction

  task automatic wr_ptr(int p);
    logic a;
    bus_start(); send(adr(1'b0), a); check("R2 addr ack", a, 0);
    send(8'(p), a); check("R3 ptr ack", a, 0); bus_stop();
    exp_ptr = p;
  endtask

  task automatic wr_reg(int p, logic [15:0] d);
    logic a;
    bus_start(); send(adr(1'b0), a); check("R2 addr ack", a, 0);
    send(8'(p), a); check("R3 ptr ack", a, 0);
    send(d[15:8], a); check("R4 msb ack", a, 0);
    send(d[7:0], a);  check("R4 lsb ack", a, 0);
    bus_stop();
    exp_ptr = p;
    if (p < NREGS) exp_mem[p] = d;
  endtask

  task automatic rd_reg(string tag);
    logic a; logic [7:0] hi, lo;
    bus_start(); send(adr(1'b1), a); check("R2 read addr ack", a, 0);
    recv(1'b0, hi); recv(1'b1, lo); bus_stop();
    check(tag, {hi, lo}, expect_rd());
  endtask

  task automatic gc_cmd(logic [7:0] c);
    logic a;
    bus_start(); send(8'h00, a); check("R7 gc addr ack", a, 0);
    send(c, a); check("R7 gc cmd ack", a, 0); bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a; logic [7:0] hi, lo;
    void'($urandom(32'd4242));
    for (int i = 0; i < NREGS; i++) exp_mem[i] = dflt(i);
    wt(5); rst_n = 1'b1; wt(5);
    check("R11 reset oe", sda_oe, 0);
    check("R5 reset ptr", rf_ptr, 0);

    // R3 R4 R5: write then read twice without pointer rewrite
    wr_reg(1, 16'h1234);
    rd_reg("R5 read back");
    rd_reg("R5 pointer persists");

    // R2: wrong address not acknowledged
    bus_start(); send(adr(1'b0) ^ 8'h02, a); check("R2 mismatch nack", a, 1);
    send(8'h03, a); check("R2 no drive after mismatch", a, 1); bus_stop();
    rd_reg("R5 ptr kept after foreign write");

    // R4: four data bytes form two words, last one wins
    bus_start(); send(adr(1'b0), a); send(8'h02, a);
    send(8'h11, a); send(8'h22, a); send(8'h33, a); check("R4 third byte ack", a, 0);
    send(8'h44, a); check("R4 fourth byte ack", a, 0); bus_stop();
    exp_ptr = 2; exp_mem[2] = 16'h3344;
    rd_reg("R4 multi-word write");

    // R9: pointer past last register
    wr_reg(6, 16'hBEEF);
    rd_reg("R9 unimplemented reads zero");
    for (int i = 0; i < NREGS; i++) begin
      wr_ptr(i); rd_reg("R9 write dropped");
    end

    // R6: master NACK on high byte ends read
    wr_ptr(3);
    bus_start(); send(adr(1'b1), a); recv(1'b1, hi);
    check("R6 high byte", hi, expect_rd() >> 8);
    wt(Q); check("R6 released after nack", sda_oe, 0);
    scl = 1'b1; wt(Q); check("R6 line idle", sda_line, 1); scl = 1'b0; wt(Q);
    bus_stop();

    // R1: traffic after STOP without START is ignored
    send(adr(1'b0), a); check("R1 no ack without start", a, 1);
    send(8'h00, a); check("R1 still silent", a, 1);
    bus_stop();
    rd_reg("R1 ptr unaffected");

    // R10: repeated START partway through a byte
    bus_start(); send_bits(8'hA5, 4);
    bus_start(); send(adr(1'b0), a); check("R10 restart addr ack", a, 0);
    send(8'h00, a); send(8'h5A, a); send(8'hC3, a); check("R10 data ack", a, 0);
    bus_stop(); exp_ptr = 0; exp_mem[0] = 16'h5AC3;
    rd_reg("R10 write after restart");

    // R7: strap change only takes effect on general call
    pins = 2'b11;
    bus_start(); send(adr(1'b0), a); check("R7 old addr before relatch", a, 0); bus_stop();
    gc_cmd(8'h04);
    bus_start(); send(adr(1'b0), a); check("R7 old addr after relatch", a, 1); bus_stop();
    cur_pins = 2'b11;
    rd_reg("R7 relatch keeps regs and ptr");

    // R8: reset command restores defaults and pointer 0
    wr_reg(3, 16'h0F0F);
    pins = 2'b10;
    gc_cmd(8'h06);
    cur_pins = 2'b10; exp_ptr = 0;
    for (int i = 0; i < NREGS; i++) exp_mem[i] = dflt(i);
    check("R8 ptr cleared", rf_ptr, 0);
    rd_reg("R8 default without ptr write");
    wr_ptr(3); rd_reg("R8 reg3 default");

    // random mix
    for (int n = 0; n < 30; n++) begin
      int op, p;
      op = int'($urandom % 3); p = int'($urandom % 6);
      case (op)
        0: wr_reg(p, 16'($urandom));
        1: wr_ptr(p);
        default: rd_reg("R5 random read");
      endcase
    end
    for (int i = 0; i < NREGS; i++) begin
      wr_ptr(i); rd_reg("R4 final contents");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule